// File: doc/BRIEF.md
# Quad serial flash read controller

This block runs one read transaction at a time against a serial NOR flash. A request carries an instruction byte, a 32-bit address, an address-length select, an address-lane select, a dummy-cycle count and a byte count. The controller lowers chip select and clocks out the instruction on one lane. It then sends the address on one or four lanes and waits the dummy cycles with every lane released. Finally it gathers the returned bytes from four lanes, two serial clocks per byte, and presents each byte with a single-cycle strobe.

The serial clock is the system clock divided by an even ratio, two times `div_i`, and idles low, so the flash samples on rising edges. For fast links, where the flash output arrives late, returned data can be captured on the falling edge that closes each serial clock instead of the rising edge that opens it. All settings are captured when a request is accepted and stay fixed until the controller is idle again.

Top module: `qspi_rd_ctrl`

## Requirements
- R1: Out of reset and whenever idle, cs_no is 1, sclk_o is 0, busy_o is 0, io_oe_o is 4'b0000 and rd_valid_o is 0.
- R2: Every high and low phase of sclk_o lasts div_i system cycles, with a div_i of 0 treated as 1; the first rising edge comes div_i system cycles after cs_no falls.
- R3: The first 8 serial clocks carry the instruction on io_o[0], most significant bit first, with io_oe_o = 4'b0001.
- R4: The address follows with 32 bits when addr4_i is 1, or with the low 24 bits when it is 0, most significant bit first. With quad_addr_i = 0 it uses one bit per clock on io_o[0] with io_oe_o = 4'b0001. With quad_addr_i = 1 it uses four bits per clock, io_o[3] carrying the most significant bit of each nibble, with io_oe_o = 4'b1111.
- R5: dummy_i serial clocks follow the address, with a value of 0 treated as 1; io_oe_o is 4'b0000 from the first dummy clock to the end of the transaction.
- R6: len_i+1 bytes are returned. Each takes two serial clocks, with the high nibble first and io_i[3] as the most significant bit of each nibble. Each byte appears on rd_data_o with rd_valid_o high for exactly one system cycle.
- R7: With fall_smp_i = 0 the nibble of a serial clock is sampled at its rising edge; with fall_smp_i = 1 it is sampled at the falling edge that ends that serial clock.
- R8: A transaction has exactly 8 + address clocks + effective dummy + 2*(len_i+1) rising edges of sclk_o, and cs_no rises div_i system cycles after the last falling edge.
- R9: busy_o rises when start_i is accepted in idle and falls 2*div_i system cycles after cs_no rises. A start_i while busy is ignored, and input changes after acceptance do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a read (taken only when idle) |
| instr_i | input | 8 | Instruction byte |
| addr_i | input | 32 | Flash address |
| addr4_i | input | 1 | 1: 4-byte address, 0: 3-byte address |
| quad_addr_i | input | 1 | 1: address on four lanes, 0: on one lane |
| dummy_i | input | 4 | Dummy serial clocks (0 acts as 1) |
| len_i | input | LEN_W | Bytes to read minus one |
| div_i | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| fall_smp_i | input | 1 | 1: capture read data on falling edge |
| busy_o | output | 1 | Transaction in progress |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| io_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_i | input | 4 | Lane input values |
| rd_data_o | output | 8 | Returned byte |
| rd_valid_o | output | 1 | One-cycle strobe for rd_data_o |

## Verification
A wrong cycle counter or a wrong phase boundary moves the instruction, address and dummy windows. The shifted address bits, a lane enable in the wrong window, or a changed rising-edge count then show up in the very transaction where the counter went wrong. A slip in the nibble pairing or in the sampling edge corrupts every returned byte from the first one on, and the bench's flash model is built so that sampling on the wrong edge yields the neighbouring nibble. Divider or tail-timer faults change the measured sclk_o phase widths and the chip-select hold and recovery intervals on the first transaction that uses them, and the sweep covers three divider settings.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  localparam int unsigned LANES   = 4;
  localparam int unsigned CMD_CYC = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL, ST_GAP} seq_st_e;
  typedef enum logic [1:0] {PH_CMD, PH_ADR, PH_DMY, PH_DAT} phase_e;

  // serial clocks spent on the address
  function automatic logic [5:0] addr_cycles(input logic four_b, input logic quad);
    logic [5:0] bits;
    bits = four_b ? 6'd32 : 6'd24;
    return quad ? (bits >> 2) : bits;
  endfunction
endpackage

// File: rtl/qspi_rd_sclk.sv
module qspi_rd_sclk #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] ONE = 1;

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             hit;

  assign hit = en_i && (cnt_q == half_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = hit & ~sclk_q;
  assign fall_o = hit & sclk_q;

  // R2: back-to-back toggles only with a one-cycle half period
  a_r2_edge_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> (!(rise_o || fall_o) || half_i == ONE));
endmodule

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
  import qspi_rd_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             addr4_i,
  input  logic             quad_i,
  input  logic [3:0]       dummy_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fall_i,
  output logic             accept_o,
  output seq_st_e          st_o,
  output phase_e           ph_o,
  output logic [DIV_W-1:0] half_o,
  output logic             cs_no
);
  localparam int unsigned      CNT_W = LEN_W + 7;
  localparam logic [CNT_W-1:0] C_ONE = 1;
  localparam logic [CNT_W-1:0] C_CMD = CNT_W'(CMD_CYC);
  localparam logic [DIV_W:0]   T_ONE = 1;
  localparam logic [DIV_W-1:0] D_ONE = 1;

  seq_st_e          st_q;
  logic [CNT_W-1:0] cyc_q, adr_end_q, dmy_end_q, last_q;
  logic [CNT_W-1:0] adr_end_d, dmy_end_d, last_d;
  logic [DIV_W-1:0] half_q;
  logic [DIV_W:0]   tmr_q;
  logic             cs_n_q;
  logic [3:0]       dmy_eff;
  logic [LEN_W:0]   nbytes;

  always_comb begin
    dmy_eff   = (dummy_i == 4'd0) ? 4'd1 : dummy_i;
    nbytes    = {1'b0, len_i} + {{LEN_W{1'b0}}, 1'b1};
    adr_end_d = C_CMD + CNT_W'(addr_cycles(addr4_i, quad_i));
    dmy_end_d = adr_end_d + CNT_W'(dmy_eff);
    last_d    = dmy_end_d + (CNT_W'(nbytes) << 1) - C_ONE;
  end

  assign accept_o = start_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cyc_q     <= '0;
      adr_end_q <= '0;
      dmy_end_q <= '0;
      last_q    <= '0;
      half_q    <= D_ONE;
      tmr_q     <= '0;
      cs_n_q    <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_RUN;
          cyc_q     <= '0;
          adr_end_q <= adr_end_d;
          dmy_end_q <= dmy_end_d;
          last_q    <= last_d;
          half_q    <= (div_i == '0) ? D_ONE : div_i;
          cs_n_q    <= 1'b0;
        end
        ST_RUN: if (fall_i) begin
          if (cyc_q == last_q) begin
            st_q  <= ST_TAIL;
            tmr_q <= '0;
          end else begin
            cyc_q <= cyc_q + C_ONE;
          end
        end
        ST_TAIL: if (tmr_q == {1'b0, half_q} - T_ONE) begin
          st_q   <= ST_GAP;
          tmr_q  <= '0;
          cs_n_q <= 1'b1;
        end else begin
          tmr_q <= tmr_q + T_ONE;
        end
        ST_GAP: if (tmr_q == {half_q, 1'b0} - T_ONE) begin
          st_q <= ST_IDLE;
        end else begin
          tmr_q <= tmr_q + T_ONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cyc_q < C_CMD)          ph_o = PH_CMD;
    else if (cyc_q < adr_end_q) ph_o = PH_ADR;
    else if (cyc_q < dmy_end_q) ph_o = PH_DMY;
    else                        ph_o = PH_DAT;
  end

  assign st_o   = st_q;
  assign half_o = half_q;
  assign cs_no  = cs_n_q;
endmodule

// File: rtl/qspi_rd_tx.sv
module qspi_rd_tx
  import qspi_rd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       instr_i,
  input  logic [31:0]      addr_i,
  input  logic             addr4_i,
  input  logic             quad_i,
  input  logic             act_i,
  input  phase_e           ph_i,
  input  logic             fall_i,
  output logic [LANES-1:0] io_o,
  output logic [LANES-1:0] io_oe_o
);
  localparam int unsigned SR_W = 40;

  logic [SR_W-1:0] sr_q;
  logic            wide, drive;

  assign wide  = quad_i && (ph_i == PH_ADR);
  assign drive = act_i && (ph_i == PH_CMD || ph_i == PH_ADR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (load_i) begin
      // 3-byte address is left-justified so the MSB leads either way
      sr_q <= {instr_i, addr4_i ? addr_i : {addr_i[23:0], 8'h00}};
    end else if (act_i && fall_i) begin
      if (ph_i == PH_CMD || (ph_i == PH_ADR && !quad_i)) sr_q <= sr_q << 1;
      else if (wide)                                      sr_q <= sr_q << LANES;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0) begin : g_lead
      assign io_o[l]    = drive & (wide ? sr_q[SR_W-LANES] : sr_q[SR_W-1]);
      assign io_oe_o[l] = drive;
    end else begin : g_side
      assign io_o[l]    = drive & wide & sr_q[SR_W-LANES+l];
      assign io_oe_o[l] = drive & wide;
    end
  end
endmodule

// File: rtl/qspi_rd_rx.sv
module qspi_rd_rx
  import qspi_rd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               win_i,
  input  logic               fall_smp_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [LANES-1:0]   io_i,
  output logic [2*LANES-1:0] data_o,
  output logic               valid_o
);
  logic             half_q;
  logic [LANES-1:0] hi_q;
  logic             smp;

  assign smp = win_i && (fall_smp_i ? fall_i : rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      hi_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        half_q <= 1'b0;
      end else if (smp) begin
        if (!half_q) begin
          hi_q   <= io_i;
          half_q <= 1'b1;
        end else begin
          data_o  <= {hi_q, io_i};
          valid_o <= 1'b1;
          half_q  <= 1'b0;
        end
      end
    end
  end

  // R6: a byte strobe never lasts two cycles
  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/qspi_rd_ctrl.sv
module qspi_rd_ctrl
  import qspi_rd_pkg::*;
#(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       instr_i,
  input  logic [31:0]      addr_i,
  input  logic             addr4_i,
  input  logic             quad_addr_i,
  input  logic [3:0]       dummy_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             fall_smp_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             cs_no,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o
);
  seq_st_e          st;
  phase_e           ph;
  logic             accept, act, rise, fall;
  logic [DIV_W-1:0] half;
  logic             quad_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quad_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (accept) begin
      quad_q <= quad_addr_i;
      fall_q <= fall_smp_i;
    end
  end

  assign act    = (st == ST_RUN);
  assign busy_o = (st != ST_IDLE);

  qspi_rd_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .addr4_i  (addr4_i),
    .quad_i   (quad_addr_i),
    .dummy_i  (dummy_i),
    .len_i    (len_i),
    .div_i    (div_i),
    .fall_i   (fall),
    .accept_o (accept),
    .st_o     (st),
    .ph_o     (ph),
    .half_o   (half),
    .cs_no    (cs_no)
  );

  qspi_rd_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (act),
    .half_i (half),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  qspi_rd_tx u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .instr_i (instr_i),
    .addr_i  (addr_i),
    .addr4_i (addr4_i),
    .quad_i  (quad_q),
    .act_i   (act),
    .ph_i    (ph),
    .fall_i  (fall),
    .io_o    (io_o),
    .io_oe_o (io_oe_o)
  );

  qspi_rd_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .win_i      (act && ph == PH_DAT),
    .fall_smp_i (fall_q),
    .rise_i     (rise),
    .fall_i     (fall),
    .io_i       (io_i),
    .data_o     (rd_data_o),
    .valid_o    (rd_valid_o)
  );

  // R1: serial clock parked low while deselected
  a_r1_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R2: clock edges only inside a selected frame
  a_r2_sclk_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> !cs_no);
  // R5: lanes released whenever a byte is delivered
  a_r5_lanes_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (io_oe_o == 4'b0000));
  // R9: chip select never low while idle
  a_r9_idle_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
endmodule

// File: tb/qspi_rd_ctrl_tb.sv
module qspi_rd_ctrl_tb;
  localparam int unsigned LEN_W = 8;
  localparam int unsigned DIV_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [7:0]       instr_i = '0;
  logic [31:0]      addr_i = '0;
  logic             addr4_i = 1'b0;
  logic             quad_addr_i = 1'b0;
  logic [3:0]       dummy_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [DIV_W-1:0] div_i = '0;
  logic             fall_smp_i = 1'b0;
  logic             busy_o, sclk_o, cs_no, rd_valid_o;
  logic [3:0]       io_o, io_oe_o;
  logic [3:0]       io_i = '0;
  logic [7:0]       rd_data_o;

  always #2.5ns clk_i = ~clk_i;

  qspi_rd_ctrl #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_dut (.*);

  int     checks = 0, errors = 0;
  bit     done = 1'b0;
  bit     e_addr4, e_quad, e_fall;
  int     e_dummy, e_len, e_div;
  logic [7:0]  e_instr;
  logic [31:0] e_addr;
  int     rise_cnt, rx_cnt, oe_err_c, oe_err_a, oe_err_d, per_err, pulse_err, cs_falls;
  longint tick = 0, last_edge, cs_rise_tick, hold_val, gap_val;
  bit     track = 1'b0, prev_v = 1'b0;
  logic [7:0]  cap_instr;
  logic [31:0] cap_addr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int acyc();
    return (e_addr4 ? 32 : 24) / (e_quad ? 4 : 1);
  endfunction
  function automatic int deff();
    return (e_dummy == 0) ? 1 : e_dummy;
  endfunction
  function automatic int dstart();
    return 8 + acyc() + deff();
  endfunction
  function automatic logic [7:0] exp_byte(input int j);
    return 8'((int'(e_addr[7:0]) * 3) + j * 29) ^ 8'hC3;
  endfunction
  function automatic logic [3:0] nib(input int n);
    logic [7:0] b;
    b = exp_byte(n / 2);
    return (n % 2 == 0) ? b[7:4] : b[3:0];
  endfunction

  // flash model: capture command side at rising edges, drive read data
  always @(posedge sclk_o) begin
    if (track && !cs_no) begin
      int c;
      c = rise_cnt;
      rise_cnt++;
      if (c < 8) begin
        cap_instr = {cap_instr[6:0], io_o[0]};
        if (io_oe_o !== 4'b0001) oe_err_c++;
      end else if (c < 8 + acyc()) begin
        if (e_quad) cap_addr = {cap_addr[27:0], io_o};
        else        cap_addr = {cap_addr[30:0], io_o[0]};
        if (io_oe_o !== (e_quad ? 4'b1111 : 4'b0001)) oe_err_a++;
      end else if (io_oe_o !== 4'b0000) begin
        oe_err_d++;
      end
      // late-output flash: nibble appears half a clock later
      if (e_fall && c >= dstart()) io_i = nib(c - dstart());
    end
  end

  always @(negedge sclk_o) begin
    if (track && !cs_no && !e_fall) begin
      int c;
      c = rise_cnt - 1;
      if (c + 1 >= dstart()) io_i = nib(c + 1 - dstart());
    end
  end

  always @(sclk_o) begin
    if (track && !cs_no) begin
      if (tick - last_edge != longint'(e_div)) per_err++;
      last_edge = tick;
    end
  end

  always @(negedge cs_no) begin
    if (track) begin
      cs_falls++;
      last_edge = tick;
    end
  end

  always @(posedge cs_no) begin
    if (track) hold_val = tick - last_edge;
    cs_rise_tick = tick;
  end

  always @(negedge busy_o) begin
    if (track) gap_val = tick - cs_rise_tick;
  end

  always @(negedge clk_i) begin
    tick++;
    if (track && rd_valid_o) begin
      chk(rd_data_o == exp_byte(rx_cnt), "R6 R7 read byte", rd_data_o, exp_byte(rx_cnt));
      rx_cnt++;
      if (prev_v) pulse_err++;
    end
    prev_v = rd_valid_o;
  end

  task automatic run_txn(input bit a4, input bit q, input bit f, input int dm, input int ln,
                         input int dv, input bit poke, input int id);
    e_addr4 = a4; e_quad = q; e_fall = f; e_dummy = dm; e_len = ln;
    e_div   = (dv == 0) ? 1 : dv;
    e_instr = 8'(id * 17 + 59);
    e_addr  = 32'h9E37_79B9 * 32'(id + 1);
    rise_cnt = 0; rx_cnt = 0; oe_err_c = 0; oe_err_a = 0; oe_err_d = 0;
    per_err = 0; pulse_err = 0; cs_falls = 0; hold_val = -1; gap_val = -1;
    cap_instr = '0; cap_addr = '0;
    track = 1'b1;
    @(negedge clk_i);
    instr_i = e_instr; addr_i = e_addr; addr4_i = a4; quad_addr_i = q;
    dummy_i = 4'(dm); len_i = LEN_W'(ln); div_i = DIV_W'(dv); fall_smp_i = f;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // disturb every input; the running transaction must not notice (R9)
    instr_i = ~e_instr; addr_i = ~e_addr; addr4_i = ~a4; quad_addr_i = ~q;
    dummy_i = 4'(dm + 5); len_i = LEN_W'(ln + 3); div_i = DIV_W'(dv + 2); fall_smp_i = ~f;
    if (poke) begin
      repeat (20) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk_i);
    track = 1'b0;
    chk(cap_instr == e_instr, "R3 instruction", cap_instr, e_instr);
    chk((cap_addr & (a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF)) == (e_addr & (a4 ? 32'hFFFF_FFFF : 32'h00FF_FFFF)),
        "R4 address", cap_addr, e_addr);
    chk(oe_err_c == 0, "R3 lane enable", oe_err_c, 0);
    chk(oe_err_a == 0, "R4 lane enable", oe_err_a, 0);
    chk(oe_err_d == 0, "R5 lanes released", oe_err_d, 0);
    chk(rise_cnt == dstart() + 2 * (ln + 1), "R8 R5 rising edge count", rise_cnt, dstart() + 2 * (ln + 1));
    chk(per_err == 0, "R2 half period", per_err, 0);
    chk(rx_cnt == ln + 1, "R6 byte count", rx_cnt, ln + 1);
    chk(pulse_err == 0, "R6 valid pulse width", pulse_err, 0);
    chk(hold_val == longint'(e_div), "R8 cs hold", hold_val, e_div);
    chk(gap_val == longint'(2 * e_div), "R9 busy recovery", gap_val, 2 * e_div);
    chk(cs_falls == 1, "R9 single frame", cs_falls, 1);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int id;
    int dms[4] = '{0, 1, 7, 15};
    id = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no == 1'b1, "R1 cs idle", cs_no, 1);
    chk(sclk_o == 1'b0, "R1 sclk idle", sclk_o, 0);
    chk(busy_o == 1'b0, "R1 busy idle", busy_o, 0);
    chk(io_oe_o == 4'b0000, "R1 lanes idle", io_oe_o, 0);
    chk(rd_valid_o == 1'b0, "R1 valid idle", rd_valid_o, 0);

    for (int a4 = 0; a4 < 2; a4++)
      for (int q = 0; q < 2; q++)
        for (int f = 0; f < 2; f++)
          for (int di = 0; di < 4; di++)
            for (int ln = 0; ln < 4; ln += 2)
              for (int dv = 1; dv < 4; dv += 2) begin
                run_txn(a4[0], q[0], f[0], dms[di], ln, dv, 1'b0, id);
                id++;
              end

    run_txn(1'b1, 1'b1, 1'b0, 3, 1, 0, 1'b0, id++);  // R2 divider 0 acts as 1
    run_txn(1'b0, 1'b0, 1'b1, 2, 3, 2, 1'b1, id++);  // R9 start while busy
    run_txn(1'b1, 1'b1, 1'b1, 4, 2, 2, 1'b1, id++);  // R9 start while busy
    run_txn(1'b1, 1'b0, 1'b0, 15, 255, 1, 1'b0, id++); // R6 longest burst

    chk(cs_no == 1'b1 && busy_o == 1'b0, "R1 idle after traffic", {busy_o, cs_no}, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule